// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block controls a six-pin general-purpose I/O port whose pins can also be lent to two serial peripherals, one UART-style and one SPI. Software reaches four byte-wide registers over a simple synchronous register bus:

- **pin value**: latched output data, or the sampled pin level when read.
- **direction**: a 1 makes the pin an output.
- **pullup enable**
- **slew-rate enable**

For each pin the block arbitrates between software and the peripheral. It produces a pad output value, an output enable, a pullup enable and a slew enable. The pads themselves and the peripherals are outside the block.

A pin is owned by a peripheral whenever that pin's `periphOwn` input is high. While it is owned, the peripheral supplies both the output value and the output enable, and the software direction bit has no say over them. The pullup and slew controls still come from software. The pullup is always gated off by a direction bit of 1, whoever owns the pin. Pin levels go through a two-flop synchronizer before software can read them.

Top module: `gpio_shared_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every register reads 0. `padOe` is 0 on every pin not owned by a peripheral. `padPull` and `padSlew` are 0 on every pin.
- R2: On a pin whose direction bit is 0, the pin-value register (address 0) returns the `padIn` level sampled two rising clock edges earlier.
- R3: On a pin whose direction bit is 1, address 0 reads back the latched data bit. On such a pin that is not peripheral-owned, `padOut` carries that bit and `padOe` is 1.
- R4: A write to address 0 latches all six bits, including bits of pins that are currently inputs. Those bits appear on reads and on `padOut` once the pin becomes an output.
- R5: The register map is fixed. Address 0 is pin value, address 1 is direction, address 2 is pullup and address 3 is slew. Bit i of each register belongs to pin i. All four are read/write, and bits 7:6 always read 0.
- R6: When `periphOwn[i]` is 1, `padOut[i]` equals `periphOut[i]` and `padOe[i]` equals `periphOe[i]`, whatever direction bit i holds.
- R7: `padPull[i]` is 1 exactly when pullup bit i is 1 and direction bit i is 0. This holds for peripheral-owned pins too.
- R8: `padSlew[i]` equals slew bit i, whether or not a peripheral owns the pin.
- R9: A write takes effect at the clock edge where `busSel` and `busWr` are both high. During a cycle with `busSel` high and `busWr` low, `busRdata` shows the addressed register in that same cycle. In every other cycle `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the read cycle |
| padIn | input | 6 | Pin levels seen from the pads |
| periphOwn | input | 6 | Per pin, 1 hands the pin to a peripheral |
| periphOut | input | 6 | Peripheral output value |
| periphOe | input | 6 | Peripheral output enable |
| padOut | output | 6 | Value driven to each pad |
| padOe | output | 6 | Output enable for each pad |
| padPull | output | 6 | Pullup enable for each pad |
| padSlew | output | 6 | Slew-rate enable for each pad |

## Verification
Two events can land in the same cycle: a software write to the direction or pullup register, and a peripheral taking or releasing the same pin. The bench provokes this by toggling `periphOwn`, `periphOe` and `padIn` with pseudo-random values in the very cycles that carry register writes and reads. A behavioural reference model then judges every cycle. It recomputes the output enable, pullup gating and read-back value from its own register copies and synchronizer history, and compares all five outputs on each clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_COUNT  = 6;
  localparam int REG_BITS   = 8;
  localparam int ADDR_BITS  = 2;

  typedef enum logic [ADDR_BITS-1:0] {
    ADDR_VALUE = 2'd0,
    ADDR_DIR   = 2'd1,
    ADDR_PULL  = 2'd2,
    ADDR_SLEW  = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic     wrValue;
    logic     wrDir;
    logic     wrPull;
    logic     wrSlew;
    logic     rdEn;
    regAddr_t rdSel;
  } regStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_BITS-1:0] busAddr,
  output regStrobe_t           strobes
);
  always_comb begin
    strobes       = '0;
    strobes.rdSel = regAddr_t'(busAddr);
    strobes.rdEn  = busSel && !busWr;
    if (busSel && busWr) begin
      unique case (regAddr_t'(busAddr))
        ADDR_VALUE: strobes.wrValue = 1'b1;
        ADDR_DIR:   strobes.wrDir   = 1'b1;
        ADDR_PULL:  strobes.wrPull  = 1'b1;
        ADDR_SLEW:  strobes.wrSlew  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PINS  = PIN_COUNT,
  parameter int REG_W = REG_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobes,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic [PINS-1:0]  padIn,
  input  logic [PINS-1:0]  periphOwn,
  input  logic [PINS-1:0]  periphOut,
  input  logic [PINS-1:0]  periphOe,
  output logic [PINS-1:0]  padOut,
  output logic [PINS-1:0]  padOe,
  output logic [PINS-1:0]  padPull,
  output logic [PINS-1:0]  padSlew
);
  localparam int FILL_W = REG_W - PINS;

  logic [PINS-1:0] valueReg, dirReg, pullReg, slewReg;
  logic [PINS-1:0] syncA, syncB;
  logic [PINS-1:0] pinView, regView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueReg <= '0;
      dirReg   <= '0;
      pullReg  <= '0;
      slewReg  <= '0;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      if (strobes.wrValue) valueReg <= busWdata[PINS-1:0];
      if (strobes.wrDir)   dirReg   <= busWdata[PINS-1:0];
      if (strobes.wrPull)  pullReg  <= busWdata[PINS-1:0];
      if (strobes.wrSlew)  slewReg  <= busWdata[PINS-1:0];
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      padOut[i]  = periphOwn[i] ? periphOut[i] : valueReg[i];
      padOe[i]   = periphOwn[i] ? periphOe[i]  : dirReg[i];
      padPull[i] = pullReg[i] & ~dirReg[i];
      padSlew[i] = slewReg[i];
      pinView[i] = dirReg[i] ? valueReg[i] : syncB[i];
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      ADDR_VALUE: regView = pinView;
      ADDR_DIR:   regView = dirReg;
      ADDR_PULL:  regView = pullReg;
      ADDR_SLEW:  regView = slewReg;
      default:    regView = '0;
    endcase
    busRdata = strobes.rdEn ? {{FILL_W{1'b0}}, regView} : '0;
  end

  // R4: a data write lands in every bit at the next edge
  p_value_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrValue |=> valueReg == $past(busWdata[PINS-1:0]));

  // R1: first cycle out of reset leaves non-owned pins undriven
  p_reset_hiz_r1: assert property (@(posedge clk)
    $rose(rstN) |-> ((padOe & ~periphOwn) == '0 && padPull == '0 && padSlew == '0));

  // R6: output enable only moves when a direction write or peripheral input moves
  p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrDir |=> (!($stable(periphOwn) && $stable(periphOe)) || $stable(padOe)));

  // R7: pullup changes only through a pullup or direction write
  p_pull_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrPull && !strobes.wrDir) |=> $stable(padPull));

  // R8: slew changes only through a slew write
  p_slew_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSlew |=> $stable(padSlew));
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int PINS  = PIN_COUNT,
  parameter int REG_W = REG_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic [REG_W-1:0]     busWdata,
  output logic [REG_W-1:0]     busRdata,
  input  logic [PINS-1:0]      padIn,
  input  logic [PINS-1:0]      periphOwn,
  input  logic [PINS-1:0]      periphOut,
  input  logic [PINS-1:0]      periphOe,
  output logic [PINS-1:0]      padOut,
  output logic [PINS-1:0]      padOe,
  output logic [PINS-1:0]      padPull,
  output logic [PINS-1:0]      padSlew
);
  regStrobe_t strobes;

  gpio_port_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_port_datapath #(.PINS(PINS), .REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .periphOwn (periphOwn),
    .periphOut (periphOut),
    .periphOe  (periphOe),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPull   (padPull),
    .padSlew   (padSlew)
  );
endmodule

// File: tb/sim_gpio_shared_port.sv
module sim_gpio_shared_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [5:0] padIn = '0, periphOwn = '0, periphOut = '0, periphOe = '0;
  logic [5:0] padOut, padOe, padPull, padSlew;

  int nChecks = 0;
  int nBad = 0;

  // reference model state
  logic [5:0] mValue, mDir, mPull, mSlew, mHist1, mHist2;

  always #5 clk = ~clk;

  gpio_shared_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .periphOwn(periphOwn),
    .periphOut(periphOut), .periphOe(periphOe), .padOut(padOut), .padOe(padOe),
    .padPull(padPull), .padSlew(padSlew)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [5:0] eOut, eOe, eView;
    logic [7:0] eRd;
    for (int i = 0; i < 6; i++) begin
      eOut[i]  = periphOwn[i] ? periphOut[i] : mValue[i];
      eOe[i]   = periphOwn[i] ? periphOe[i]  : mDir[i];
      eView[i] = mDir[i] ? mValue[i] : mHist2[i];
    end
    eRd = 8'h00;
    if (busSel && !busWr) begin
      case (busAddr)
        2'd0: eRd = {2'b00, eView};
        2'd1: eRd = {2'b00, mDir};
        2'd2: eRd = {2'b00, mPull};
        default: eRd = {2'b00, mSlew};
      endcase
    end
    chk("R3/R4/R6 padOut", {2'b00, padOut}, {2'b00, eOut});
    chk("R1/R3/R6 padOe", {2'b00, padOe}, {2'b00, eOe});
    chk("R7 padPull", {2'b00, padPull}, {2'b00, mPull & ~mDir});
    chk("R8 padSlew", {2'b00, padSlew}, {2'b00, mSlew});
    chk("R2/R5/R9 busRdata", busRdata, eRd);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      mValue = '0; mDir = '0; mPull = '0; mSlew = '0; mHist1 = '0; mHist2 = '0;
    end else begin
      if (busSel && busWr) begin
        case (busAddr)
          2'd0: mValue = busWdata[5:0];
          2'd1: mDir   = busWdata[5:0];
          2'd2: mPull  = busWdata[5:0];
          default: mSlew = busWdata[5:0];
        endcase
      end
      mHist2 = mHist1;
      mHist1 = padIn;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    tick();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    tick();
    busSel = 1'b0;
  endtask

  initial begin
    #2000000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    // R1: reset with busy inputs
    padIn = 6'h3F; periphOut = 6'h15;
    repeat (3) tick();
    rstN = 1'b1;
    rd(2'd1);
    rd(2'd0);
    // R2: input pins show synchronized pin level
    padIn = 6'h2A;
    rd(2'd0); rd(2'd0); rd(2'd0);
    // R4: write latched on input pins, then R3 exposes it
    wr(2'd0, 8'hFF);
    rd(2'd0);
    wr(2'd1, 8'h3F);
    rd(2'd0);
    // R5: upper bits read zero on every register
    wr(2'd2, 8'hFF); rd(2'd2);
    wr(2'd3, 8'hC9); rd(2'd3);
    // R7: pullup gated by direction
    wr(2'd1, 8'h0F); rd(2'd1);
    // R6/R8: peripheral takes pins, direction ignored
    periphOwn = 6'h33; periphOut = 6'h21; periphOe = 6'h12;
    rd(2'd0);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h3F);
    periphOwn = 6'h00;
    rd(2'd0);
    // mixed random phase: bus traffic together with ownership changes
    for (int k = 0; k < 600; k++) begin
      padIn     = 6'($urandom);
      periphOwn = 6'($urandom);
      periphOut = 6'($urandom);
      periphOe  = 6'($urandom);
      busSel    = 1'($urandom);
      busWr     = 1'($urandom);
      busAddr   = 2'($urandom);
      busWdata  = 8'($urandom);
      if (k == 300) rstN = 1'b0;
      if (k == 303) rstN = 1'b1;
      tick();
    end
    busSel = 1'b0;
    tick();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule